// File: doc/BRIEF.md
# Serial Port Line Status Tracker

This block builds the 8-bit line status word for an asynchronous serial port that has a receive FIFO and a transmit FIFO. The receiver side strobes in each finished character along with three error tags: bad parity, missing stop bit, and a word that stayed silent for a full character time. Each character and its tags are stored together in a small receive FIFO. The transmitter side reports three things: CPU writes into the holding stage, transfers from holding into the shift stage, and the empty levels of its FIFO and shift register.

The CPU reads the status word through a read strobe. The value returned is the one held before the read. On the next clock edge, the read clears the per-character error flags and the overrun flag. A summary error flag is also kept. It stays set across status reads for as long as any character stored with an error tag is still in the receive FIFO. A level interrupt asks for the next transmit character while the holding stage is empty and the enable input is high.

Two small state machines carry the sticky behaviour. The holding tracker has states `HOLD_EMPTY` and `HOLD_FULL`. A CPU write with no transfer in the same cycle moves it from `HOLD_EMPTY` to `HOLD_FULL`. A transfer moves it from `HOLD_FULL` back to `HOLD_EMPTY`, and a transfer wins over a write in the same cycle. The summary tracker has states `SUM_CLEAN` and `SUM_PENDING`. Storing a tagged character moves it from `SUM_CLEAN` to `SUM_PENDING`. A status read moves it back to `SUM_CLEAN` only when no tagged entry is in the FIFO and no tagged character is being stored in that same cycle.

Top module: `sio_status_tracker`

## Requirements
- R1: After reset the status word is 8'h60: bits 5 and 6 are set and all others are clear. With the enable low, `tx_irq` is 0.
- R2: Bit 0 is 1 while the receive FIFO holds at least one character and 0 when it is empty. `rx_data` shows the oldest stored character, and `rx_pop` removes it, so characters come out in arrival order.
- R3: A character that arrives while the FIFO holds DEPTH entries is discarded, even if a pop happens in the same cycle, and it sets bit 1. A status read clears bit 1.
- R4: A character arriving with `rx_par_err` sets bit 2, with `rx_stop_err` sets bit 3, and with `rx_silent` sets bit 4. Each of these bits clears on a status read.
- R5: `status` during a read cycle shows the value from before the read. The clear takes effect at the following clock edge. If a set event and a status read fall in the same cycle, the bit ends up set.
- R6: Bit 7 sets when a character with any error tag is stored in the FIFO. A status read clears it only if no tagged entry remains in the FIFO. Without a read, it stays set.
- R7: Bit 5 resets to 1 and sets on `tx_xfer`. It clears on `tx_wr`. When both occur in the same cycle, it stays 1.
- R8: Bit 6 becomes, one clock later, the AND of `tx_fifo_empty` and `tx_shift_idle`.
- R9: `tx_irq` is high exactly when bit 5 is 1 and `tx_irq_en` is 1. It follows the enable with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_char_vld | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error tag for the strobed character |
| rx_stop_err | input | 1 | Missing stop bit tag for the strobed character |
| rx_silent | input | 1 | Silent word tag for the strobed character |
| rx_pop | input | 1 | CPU read of the oldest received character |
| rx_data | output | 8 | Oldest character in the receive FIFO |
| stat_rd | input | 1 | CPU read strobe for the status word |
| status | output | 8 | Status word |
| tx_wr | input | 1 | CPU write into the transmit holding stage or FIFO |
| tx_xfer | input | 1 | Transfer from holding stage to shift register |
| tx_fifo_empty | input | 1 | Transmit FIFO empty level |
| tx_shift_idle | input | 1 | Transmit shift register empty level |
| tx_irq_en | input | 1 | Transmit-empty interrupt enable |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The assertions check the following on every cycle. A read without a concurrent receive clears bits 1 to 4 at the next edge. A transfer always leaves bit 5 set, and a write without a transfer always leaves it clear. Bit 7 never drops without a read. A received strobe always leaves bit 0 set. Both transmit-empty levels being high always sets bit 6. The interrupt is never high without both its enable and bit 5.

Some behaviours need the bench's scenarios. These are FIFO ordering, discarding on overflow, the value returned during a read, the race between a set event and a read, and the summary flag holding across reads until the last tagged entry has been popped.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;
    localparam int unsigned CHAR_W = 8;
    localparam int unsigned STAT_W = 8;
    localparam int unsigned TAG_N  = 3;

    localparam int unsigned B_DR   = 0;
    localparam int unsigned B_OVR  = 1;
    localparam int unsigned B_PAR  = 2;
    localparam int unsigned B_STP  = 3;
    localparam int unsigned B_SIL  = 4;
    localparam int unsigned B_TBE  = 5;
    localparam int unsigned B_TSE  = 6;
    localparam int unsigned B_SUM  = 7;

    typedef struct packed {
        logic [TAG_N-1:0]  tags;   // {silent, stop, parity}
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    typedef enum logic {HOLD_EMPTY, HOLD_FULL} hold_state_t;
    typedef enum logic {SUM_CLEAN, SUM_PENDING} sum_state_t;
endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo
    import sio_stat_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_req,
    input  rx_entry_t push_entry,
    input  logic      pop_req,
    output rx_entry_t head,
    output logic      not_empty,
    output logic      overrun_evt,
    output logic      tagged_push,
    output logic      tagged_any
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    rx_entry_t         mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count, tag_cnt;
    logic              full, do_push, do_pop, head_tagged;

    assign full        = (count == FULLV);
    assign not_empty   = (count != '0);
    assign do_push     = push_req && !full;
    assign do_pop      = pop_req && not_empty;
    assign head        = mem[rd_ptr];
    assign head_tagged = do_pop && (head.tags != '0);
    assign overrun_evt = push_req && full;
    assign tagged_push = do_push && (push_entry.tags != '0);
    assign tagged_any  = (tag_cnt != '0);

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            tag_cnt <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            unique case ({tagged_push, head_tagged})
                2'b10:   tag_cnt <= tag_cnt + 1'b1;
                2'b01:   tag_cnt <= tag_cnt - 1'b1;
                default: tag_cnt <= tag_cnt;
            endcase
        end
    end
endmodule

// File: rtl/sio_rx_flags.sv
module sio_rx_flags
    import sio_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_vld,
    input  logic [TAG_N-1:0] rx_tags,
    input  logic             overrun_evt,
    input  logic             stat_rd,
    input  logic             tagged_push,
    input  logic             tagged_any,
    output logic [TAG_N-1:0] err_flags,
    output logic             ovr_flag,
    output logic             sum_flag
);
    sum_state_t sum_q, sum_d;

    for (genvar g = 0; g < TAG_N; g++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n)                  err_flags[g] <= 1'b0;
            else if (rx_vld && rx_tags[g]) err_flags[g] <= 1'b1;
            else if (stat_rd)            err_flags[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           ovr_flag <= 1'b0;
        else if (overrun_evt) ovr_flag <= 1'b1;
        else if (stat_rd)     ovr_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sum_q <= SUM_CLEAN;
        else        sum_q <= sum_d;
    end

    always_comb begin
        sum_d = sum_q;
        unique case (sum_q)
            SUM_CLEAN:   if (tagged_push) sum_d = SUM_PENDING;
            SUM_PENDING: if (stat_rd && !tagged_any && !tagged_push) sum_d = SUM_CLEAN;
            default:     sum_d = SUM_CLEAN;
        endcase
    end

    always_comb begin
        sum_flag = (sum_q == SUM_PENDING);
    end
endmodule

// File: rtl/sio_tx_hold.sv
module sio_tx_hold
    import sio_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_wr,
    input  logic tx_xfer,
    input  logic tx_fifo_empty,
    input  logic tx_shift_idle,
    output logic hold_empty,
    output logic all_empty
);
    hold_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= HOLD_EMPTY;
            all_empty <= 1'b1;
        end else begin
            st_q      <= st_d;
            all_empty <= tx_fifo_empty && tx_shift_idle;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HOLD_EMPTY: if (tx_wr && !tx_xfer) st_d = HOLD_FULL;
            HOLD_FULL:  if (tx_xfer) st_d = HOLD_EMPTY;
            default:    st_d = HOLD_EMPTY;
        endcase
    end

    always_comb begin
        hold_empty = (st_q == HOLD_EMPTY);
    end
endmodule

// File: rtl/sio_status_tracker.sv
module sio_status_tracker
    import sio_stat_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_char_vld,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_par_err,
    input  logic              rx_stop_err,
    input  logic              rx_silent,
    input  logic              rx_pop,
    output logic [CHAR_W-1:0] rx_data,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] status,
    input  logic              tx_wr,
    input  logic              tx_xfer,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_idle,
    input  logic              tx_irq_en,
    output logic              tx_irq
);
    rx_entry_t         in_entry, head;
    logic              not_empty, overrun_evt, tagged_push, tagged_any;
    logic [TAG_N-1:0]  err_flags;
    logic              ovr_flag, sum_flag, hold_empty, all_empty;

    assign in_entry.data = rx_char;
    assign in_entry.tags = {rx_silent, rx_stop_err, rx_par_err};

    sio_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_req(rx_char_vld), .push_entry(in_entry), .pop_req(rx_pop),
        .head(head), .not_empty(not_empty), .overrun_evt(overrun_evt),
        .tagged_push(tagged_push), .tagged_any(tagged_any)
    );

    sio_rx_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .rx_vld(rx_char_vld), .rx_tags(in_entry.tags),
        .overrun_evt(overrun_evt), .stat_rd(stat_rd),
        .tagged_push(tagged_push), .tagged_any(tagged_any),
        .err_flags(err_flags), .ovr_flag(ovr_flag), .sum_flag(sum_flag)
    );

    sio_tx_hold u_tx (
        .clk(clk), .rst_n(rst_n),
        .tx_wr(tx_wr), .tx_xfer(tx_xfer),
        .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
        .hold_empty(hold_empty), .all_empty(all_empty)
    );

    always_comb begin
        status        = '0;
        status[B_DR]  = not_empty;
        status[B_OVR] = ovr_flag;
        status[B_PAR] = err_flags[0];
        status[B_STP] = err_flags[1];
        status[B_SIL] = err_flags[2];
        status[B_TBE] = hold_empty;
        status[B_TSE] = all_empty;
        status[B_SUM] = sum_flag;
        rx_data       = head.data;
        tx_irq        = hold_empty && tx_irq_en;
    end
endmodule

// File: rtl/sio_status_tracker_chk.sv
module sio_status_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_char_vld,
    input logic       stat_rd,
    input logic [7:0] status,
    input logic       tx_wr,
    input logic       tx_xfer,
    input logic       tx_fifo_empty,
    input logic       tx_shift_idle,
    input logic       tx_irq_en,
    input logic       tx_irq
);
    AST_DR_AFTER_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_char_vld |=> status[0]); // R2
    AST_OVR_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !rx_char_vld) |=> !status[1]); // R3
    AST_ERR_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !rx_char_vld) |=> (status[4:2] == 3'b000)); // R4
    AST_SUM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !stat_rd) |=> status[7]); // R6
    AST_TBE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_xfer |=> status[5]); // R7
    AST_TBE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !tx_xfer) |=> !status[5]); // R7
    AST_TSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fifo_empty && tx_shift_idle) |=> status[6]); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> (tx_irq_en && status[5])); // R9
endmodule

bind sio_status_tracker sio_status_tracker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_char_vld(rx_char_vld), .stat_rd(stat_rd),
    .status(status), .tx_wr(tx_wr), .tx_xfer(tx_xfer),
    .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
    .tx_irq_en(tx_irq_en), .tx_irq(tx_irq)
);

// File: tb/tb_sio_status_tracker.sv
module tb_sio_status_tracker;
    localparam int unsigned D = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_char_vld = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_par_err = 1'b0, rx_stop_err = 1'b0, rx_silent = 1'b0;
    logic       rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic       stat_rd = 1'b0;
    logic [7:0] status;
    logic       tx_wr = 1'b0, tx_xfer = 1'b0;
    logic       tx_fifo_empty = 1'b1, tx_shift_idle = 1'b1;
    logic       tx_irq_en = 1'b0;
    logic       tx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sio_status_tracker #(.DEPTH(D)) dut (
        .clk(clk), .rst_n(rst_n),
        .rx_char_vld(rx_char_vld), .rx_char(rx_char),
        .rx_par_err(rx_par_err), .rx_stop_err(rx_stop_err), .rx_silent(rx_silent),
        .rx_pop(rx_pop), .rx_data(rx_data),
        .stat_rd(stat_rd), .status(status),
        .tx_wr(tx_wr), .tx_xfer(tx_xfer),
        .tx_fifo_empty(tx_fifo_empty), .tx_shift_idle(tx_shift_idle),
        .tx_irq_en(tx_irq_en), .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] tags);
        rx_char_vld = 1'b1; rx_char = d;
        {rx_silent, rx_stop_err, rx_par_err} = tags;
        step();
        rx_char_vld = 1'b0; {rx_silent, rx_stop_err, rx_par_err} = 3'b000;
    endtask

    task automatic pop();
        rx_pop = 1'b1; step(); rx_pop = 1'b0;
    endtask

    task automatic sread(output logic [7:0] pre);
        stat_rd = 1'b1; #0.5; pre = status; step(); stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset status", status, 8'h60);
        chk("R1 reset irq", tx_irq, 1'b0);
    endtask

    task automatic t_rx_order();
        push(8'hA5, 3'b000);
        push(8'h3C, 3'b000);
        chk("R2 ready set", status[0], 1'b1);
        chk("R2 clean flags", status[4:1], 4'h0);
        chk("R2 head first", rx_data, 8'hA5);
        pop();
        chk("R2 head second", rx_data, 8'h3C);
        chk("R2 ready still", status[0], 1'b1);
        pop();
        chk("R2 ready clear", status[0], 1'b0);
    endtask

    task automatic t_err_flags();
        logic [7:0] pre;
        push(8'h11, 3'b001);
        chk("R4 parity set", status[2], 1'b1);
        chk("R6 summary set", status[7], 1'b1);
        sread(pre);
        chk("R5 pre-read parity", pre[2], 1'b1);
        chk("R4 parity clear", status[2], 1'b0);
        push(8'h22, 3'b010);
        chk("R4 stop set", status[3], 1'b1);
        push(8'h33, 3'b100);
        chk("R4 silent set", status[4], 1'b1);
        sread(pre);
        chk("R4 all error clear", status[4:2], 3'b000);
        pop(); pop(); pop();
        sread(pre);
        chk("R6 summary clear after drain", status[7], 1'b0);
    endtask

    task automatic t_sum_sticky();
        logic [7:0] pre;
        push(8'h40, 3'b000);
        push(8'h41, 3'b001);
        sread(pre);
        chk("R6 summary held by entry", status[7], 1'b1);
        pop();
        sread(pre);
        chk("R6 summary held second read", status[7], 1'b1);
        pop();
        step();
        chk("R6 summary held without read", status[7], 1'b1);
        sread(pre);
        chk("R6 summary clears", status[7], 1'b0);
    endtask

    task automatic t_race();
        logic [7:0] pre;
        stat_rd = 1'b1; rx_char_vld = 1'b1; rx_char = 8'h5A; rx_par_err = 1'b1;
        #0.5; pre = status;
        step();
        stat_rd = 1'b0; rx_char_vld = 1'b0; rx_par_err = 1'b0;
        chk("R5 pre-read no parity", pre[2], 1'b0);
        chk("R5 set wins over read", status[2], 1'b1);
        sread(pre);
        chk("R5 later read clears", status[2], 1'b0);
        pop();
        sread(pre);
        chk("R6 summary cleared", status[7], 1'b0);
    endtask

    task automatic t_overrun();
        logic [7:0] pre;
        for (int i = 0; i < D; i++) push(8'(i), 3'b000);
        chk("R3 no overrun when full", status[1], 1'b0);
        push(8'hEE, 3'b000);
        chk("R3 overrun set", status[1], 1'b1);
        sread(pre);
        chk("R3 overrun clear", status[1], 1'b0);
        for (int i = 0; i < D; i++) begin
            chk("R3 order kept", rx_data, 8'(i));
            pop();
        end
        chk("R3 extra discarded", status[0], 1'b0);
    endtask

    task automatic t_tx();
        tx_irq_en = 1'b1; #0.5;
        chk("R9 irq on enable", tx_irq, 1'b1);
        @(negedge clk);
        tx_wr = 1'b1; step(); tx_wr = 1'b0;
        chk("R7 write clears", status[5], 1'b0);
        chk("R9 irq low", tx_irq, 1'b0);
        tx_xfer = 1'b1; step(); tx_xfer = 1'b0;
        chk("R7 transfer sets", status[5], 1'b1);
        tx_wr = 1'b1; step();
        tx_xfer = 1'b1; step(); tx_wr = 1'b0; tx_xfer = 1'b0;
        chk("R7 transfer wins", status[5], 1'b1);
        tx_irq_en = 1'b0; #0.5;
        chk("R9 irq drops with enable", tx_irq, 1'b0);
        @(negedge clk);
    endtask

    task automatic t_tsre();
        tx_fifo_empty = 1'b0; step();
        chk("R8 fifo busy", status[6], 1'b0);
        tx_fifo_empty = 1'b1; tx_shift_idle = 1'b0; step();
        chk("R8 shift busy", status[6], 1'b0);
        tx_shift_idle = 1'b1; step();
        chk("R8 both empty", status[6], 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_order();
        t_err_flags();
        t_sum_sticky();
        t_race();
        t_overrun();
        t_tx();
        t_tsre();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule